// File: doc/BRIEF.md
# Output-Compare Channel Bank

This block holds a small bank of output-compare channels that watch a free-running 31-bit time counter supplied from outside. Each channel holds a mode, an interrupt enable, an event flag and a two-deep compare store. When the counter passes the channel's active compare value, the channel raises its event flag and drives its output pin. In toggle mode the pin flips. In pulse mode the pin goes high for a single cycle.

The compare store has two stages. A value written while the channel is idle becomes the active threshold. A value written while the channel runs waits behind the active one. It takes over at the next match. A periodic output, such as one pulse per second, is kept running by writing the value for the event after next from each interrupt. A match counts whenever the counter steps from below the threshold to at or above it, wrap included, so counters that advance by more than one per cycle cannot skip an event.

Top module: `cmp_pulse_bank`

## Requirements
- R1: After reset every pin and the interrupt are low, and every control and compare register reads zero.
- R2: The register address is {channel, select}. Select 0 is control and select 1 is compare. The control fields are: mode in bits 5:2, interrupt enable in bit 6, event flag in bit 7. All other control bits read zero.
- R3: A compare write while the channel's mode is zero becomes the active value at once. The compare register reads it back, and any queued value is dropped.
- R4: A compare write while the mode is nonzero and no active value is held is ignored.
- R5: A compare write while the mode is nonzero and an active value is held is queued. Readback still shows the active value. The queued value becomes active at the next match.
- R6: A match occurs in the cycle the counter input moves from below the active value to at or above it. Steps larger than one count, and a step across the counter wrap that lands at or above the value, also match. An unchanged counter never matches.
- R7: A match sets the event flag. Writing control with bit 7 set clears the flag, and writing bit 7 as zero leaves it unchanged.
- R8: In mode 0x5 the channel's pin inverts on every match.
- R9: In mode 0xF the channel's pin is high for exactly the one cycle after the match edge.
- R10: In mode zero the channel never matches and its pin is low. Writing zero to control disables the channel.
- R11: The interrupt output is high when any channel has both its flag and its interrupt enable set.
- R12: Compare values keep only bits 30:0, and bit 31 of compare readback is zero.
- R13: After a match with no queued value, the channel stays silent until a new value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_i | input | 31 | Current time counter value |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | {channel, select} register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pin_o | output | 4 | Compare output pin per channel |
| irq_o | output | 1 | Combined compare interrupt |

## Verification
The assertions take for granted that the counter input only moves through the clock edge. They also assume that every register side effect comes from a write strobe, so that a pin rise or an interrupt rise can be traced to either a counter step or a write in the cycle before. The stimulus changes the counter and the register port only just after a rising edge and holds them for a whole cycle. It never writes a compare value in the same cycle as a match on that channel. That keeps the order between a reload and a match out of question.

// File: rtl/cmp_pulse_pkg.sv
package cmp_pulse_pkg;
    localparam int unsigned MODE_W      = 4;
    localparam int unsigned FLD_MODE_LO = 2;
    localparam int unsigned FLD_IE      = 6;
    localparam int unsigned FLD_FLAG    = 7;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'h0;
    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'h5;
    localparam logic [MODE_W-1:0] MODE_PULSE  = 4'hF;
endpackage

// File: rtl/cpb_cross.sv
module cpb_cross #(
    parameter int unsigned CW = 31
) (
    input  logic          prev_vld_i,
    input  logic [CW-1:0] prev_i,
    input  logic [CW-1:0] cur_i,
    input  logic [CW-1:0] thr_i,
    output logic          hit_o
);
    logic below_prev;
    logic reached_cur;
    logic wrapped;

    always_comb begin
        below_prev  = prev_i < thr_i;
        reached_cur = cur_i >= thr_i;
        wrapped     = cur_i < prev_i;
        if (!prev_vld_i) begin
            hit_o = 1'b0;
        end else if (wrapped) begin
            hit_o = below_prev || reached_cur;
        end else begin
            hit_o = below_prev && reached_cur;
        end
    end
endmodule

// File: rtl/cpb_channel.sv
module cpb_channel
    import cmp_pulse_pkg::*;
#(
    parameter int unsigned CW = 31,
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ctl_we_i,
    input  logic          cmp_we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          cnt_vld_i,
    input  logic [CW-1:0] cnt_prev_i,
    input  logic [CW-1:0] cnt_cur_i,
    output logic [DW-1:0] ctl_rd_o,
    output logic [DW-1:0] cmp_rd_o,
    output logic          pin_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              ie;
        logic              flag;
        logic [CW-1:0]     act;
        logic [CW-1:0]     nxt;
        logic              act_vld;
        logic              nxt_vld;
        logic              pin;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;
    logic     match;

    cpb_cross #(.CW(CW)) u_cross (
        .prev_vld_i (cnt_vld_i),
        .prev_i     (cnt_prev_i),
        .cur_i      (cnt_cur_i),
        .thr_i      (st_q.act),
        .hit_o      (hit)
    );

    always_comb begin
        st_d  = st_q;
        match = hit && st_q.act_vld && (st_q.mode != MODE_OFF);

        // match: raise flag, advance the two-stage compare store
        if (match) begin
            st_d.flag = 1'b1;
            if (st_q.nxt_vld) begin
                st_d.act     = st_q.nxt;
                st_d.nxt_vld = 1'b0;
            end else begin
                st_d.act_vld = 1'b0;
            end
        end

        // pin behaviour follows the mode held in the current cycle
        if (st_q.mode == MODE_TOGGLE) begin
            st_d.pin = st_q.pin ^ match;
        end else if (st_q.mode == MODE_PULSE) begin
            st_d.pin = match;
        end else begin
            st_d.pin = 1'b0;
        end

        if (ctl_we_i) begin
            st_d.mode = wdata_i[FLD_MODE_LO +: MODE_W];
            st_d.ie   = wdata_i[FLD_IE];
            if (wdata_i[FLD_FLAG] && !match) begin
                st_d.flag = 1'b0;
            end
        end

        if (cmp_we_i) begin
            if (st_q.mode == MODE_OFF) begin
                st_d.act     = wdata_i[CW-1:0];
                st_d.act_vld = 1'b1;
                st_d.nxt_vld = 1'b0;
            end else if (st_d.act_vld) begin
                st_d.nxt     = wdata_i[CW-1:0];
                st_d.nxt_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl_rd_o                            = '0;
        ctl_rd_o[FLD_MODE_LO +: MODE_W]     = st_q.mode;
        ctl_rd_o[FLD_IE]                    = st_q.ie;
        ctl_rd_o[FLD_FLAG]                  = st_q.flag;
        cmp_rd_o                            = '0;
        cmp_rd_o[CW-1:0]                    = st_q.act;
    end

    assign pin_o = st_q.pin;
    assign irq_o = st_q.flag & st_q.ie;
endmodule

// File: rtl/cmp_pulse_bank.sv
module cmp_pulse_bank #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 31,
    parameter int unsigned DW  = 32,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW  = CHW + 1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [CW-1:0]  cnt_i,
    input  logic           reg_we_i,
    input  logic [AW-1:0]  reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    output logic [NCH-1:0] pin_o,
    output logic           irq_o
);
    typedef struct packed {
        logic [CW-1:0] cnt_prev;
        logic          vld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CHW-1:0] sel_ch;
    logic           sel_cmp;
    logic [DW-1:0]  ctl_rd [NCH];
    logic [DW-1:0]  cmp_rd [NCH];
    logic [NCH-1:0] ch_irq;

    assign sel_ch  = reg_addr_i[AW-1:1];
    assign sel_cmp = reg_addr_i[0];

    always_comb begin
        st_d.cnt_prev = cnt_i;
        st_d.vld      = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit_sel;
        assign hit_sel = reg_we_i && (sel_ch == CHW'(g));

        cpb_channel #(.CW(CW), .DW(DW)) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ctl_we_i   (hit_sel && !sel_cmp),
            .cmp_we_i   (hit_sel && sel_cmp),
            .wdata_i    (reg_wdata_i),
            .cnt_vld_i  (st_q.vld),
            .cnt_prev_i (st_q.cnt_prev),
            .cnt_cur_i  (cnt_i),
            .ctl_rd_o   (ctl_rd[g]),
            .cmp_rd_o   (cmp_rd[g]),
            .pin_o      (pin_o[g]),
            .irq_o      (ch_irq[g])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel_ch == CHW'(i)) begin
                reg_rdata_o = sel_cmp ? cmp_rd[i] : ctl_rd[i];
            end
        end
    end

    assign irq_o = |ch_irq;
endmodule

// File: rtl/cmp_pulse_bank_chk.sv
module cmp_pulse_bank_chk #(
    parameter int unsigned NCH = 4,
    parameter int unsigned CW  = 31,
    parameter int unsigned DW  = 32,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int unsigned AW  = CHW + 1
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [CW-1:0]  cnt_i,
    input logic           reg_we_i,
    input logic [AW-1:0]  reg_addr_i,
    input logic [DW-1:0]  reg_rdata_o,
    input logic [NCH-1:0] pin_o,
    input logic           irq_o
);
    // R6: a pin can only rise after the counter input moved
    a_r6_pin_rise_needs_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(pin_o & ~$past(pin_o))) |-> ($past(cnt_i) != $past(cnt_i, 2)));

    // R11: interrupt rises only from a counter step or a register write
    a_r11_irq_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (($past(cnt_i) != $past(cnt_i, 2)) || $past(reg_we_i)));

    // R7: the interrupt drops only through a register write
    a_r7_irq_fall_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(reg_we_i));

    // R12: compare readback never carries bits above the counter width
    a_r12_cmp_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_addr_i[0] |-> (reg_rdata_o[DW-1:CW] == '0));
endmodule

bind cmp_pulse_bank cmp_pulse_bank_chk #(.NCH(NCH), .CW(CW), .DW(DW)) u_chk (.*);

// File: tb/test_cmp_pulse_bank.sv
module test_cmp_pulse_bank;
    localparam int NCH = 4;
    localparam int AW  = 3;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [30:0]   cnt_i = '0;
    logic          reg_we_i = 1'b0;
    logic [AW-1:0] reg_addr_i = '0;
    logic [31:0]   reg_wdata_i = '0;
    logic [31:0]   reg_rdata_o;
    logic [NCH-1:0] pin_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        int          kind;  // 0 read data, 1 pins, 2 interrupt
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    cmp_pulse_bank i_cmp_pulse_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_i       (cnt_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .pin_o       (pin_o),
        .irq_o       (irq_o)
    );

    always #5 clk_i = ~clk_i;

    // monitor: compares queued expectations half a cycle after they are posted
    initial begin
        forever begin
            @(negedge clk_i);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = reg_rdata_o;
                    1: act = {28'd0, pin_o};
                    default: act = {31'd0, irq_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk_i);
        #2;
    endtask

    task automatic post(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb.push_back(it);
        @(negedge clk_i);
        #1;
    endtask

    task automatic exp_rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
        reg_addr_i = a;
        post(0, exp, tag);
    endtask

    task automatic exp_pin(logic [3:0] exp, string tag);
        post(1, {28'd0, exp}, tag);
    endtask

    task automatic exp_irq(logic exp, string tag);
        post(2, {31'd0, exp}, tag);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_we_i    = 1'b1;
        tick();
        reg_we_i    = 1'b0;
    endtask

    task automatic step(logic [30:0] v);
        cnt_i = v;
        tick();
    endtask

    function automatic logic [AW-1:0] ctl(int ch);
        return AW'(ch * 2);
    endfunction

    function automatic logic [AW-1:0] cmp(int ch);
        return AW'(ch * 2 + 1);
    endfunction

    initial begin
        repeat (3) tick();
        rst_ni = 1'b1;
        tick();

        // R1 reset state, R2 address map
        exp_pin(4'b0000, "R1 pins after reset");
        exp_irq(1'b0, "R1 irq after reset");
        exp_rd(ctl(0), 32'h0, "R1 R2 ctl0 after reset");
        exp_rd(cmp(2), 32'h0, "R1 R2 cmp2 after reset");

        // R3, R12: load while idle, upper bit dropped
        wr(cmp(0), 32'h8000_0064);
        exp_rd(cmp(0), 32'h0000_0064, "R3 R12 masked active value");

        // R4: compare write in pulse mode with nothing active is ignored
        wr(ctl(1), 32'h7C);
        wr(cmp(1), 32'h10);
        exp_rd(cmp(1), 32'h0, "R4 ignored compare write");

        // R9, R7, R11: pulse mode on channel 1
        wr(ctl(1), 32'h0);
        wr(cmp(1), 32'h50);
        wr(ctl(1), 32'h7C);
        step(31'h40);
        exp_pin(4'b0000, "R6 below threshold no match");
        step(31'h50);
        exp_pin(4'b0010, "R9 pulse high after match");
        exp_rd(ctl(1), 32'hFC, "R7 flag set on match");
        exp_irq(1'b1, "R11 irq from flag and enable");
        step(31'h51);
        exp_pin(4'b0000, "R9 pulse lasts one cycle");
        wr(ctl(1), 32'hFC);
        exp_rd(ctl(1), 32'h7C, "R7 write one clears flag");
        exp_irq(1'b0, "R11 irq drops with flag");

        // R13: no queued value, later crossings stay silent; R10 channel 0 off
        step(31'h7FFF_FFF0);
        step(31'h10);
        step(31'h60);
        exp_pin(4'b0000, "R13 R10 no match after exhausted store");
        exp_rd(ctl(1), 32'h7C, "R13 flag stays clear");

        // R5, R8, R6: toggle with queued reloads on channel 2
        wr(ctl(2), 32'h0);
        wr(cmp(2), 32'h100);
        wr(ctl(2), 32'h14);
        wr(cmp(2), 32'h300);
        exp_rd(cmp(2), 32'h100, "R5 queued value not visible");
        step(31'h180);
        exp_pin(4'b0100, "R8 R6 toggle on wide step");
        exp_rd(cmp(2), 32'h300, "R5 queued value now active");
        exp_irq(1'b0, "R11 no irq without enable");
        wr(cmp(2), 32'h500);
        wr(ctl(2), 32'h14);
        exp_rd(ctl(2), 32'h94, "R7 write zero keeps flag");
        wr(ctl(2), 32'h94);
        exp_rd(ctl(2), 32'h14, "R7 flag cleared");
        step(31'h300);
        exp_pin(4'b0000, "R8 toggle back on exact hit");
        step(31'h400);
        exp_pin(4'b0000, "R6 no match between thresholds");
        step(31'h520);
        exp_pin(4'b0100, "R8 third toggle");
        exp_rd(cmp(2), 32'h500, "R5 second reload active");

        // R6 wrap crossing, R9 pulse on channel 3
        wr(ctl(3), 32'h0);
        wr(cmp(3), 32'h10);
        wr(ctl(3), 32'h7C);
        step(31'h7FFF_FF00);
        exp_pin(4'b0100, "R6 no match moving away");
        step(31'h20);
        exp_pin(4'b1100, "R6 match across wrap");
        exp_irq(1'b1, "R11 irq from channel 3");
        tick();
        exp_pin(4'b0100, "R6 R9 steady counter no repeat");

        // R10: clearing control disables the channel
        wr(ctl(3), 32'h0);
        exp_rd(ctl(3), 32'h80, "R10 ctl cleared flag kept");
        exp_irq(1'b0, "R11 irq off with enable cleared");
        wr(cmp(3), 32'h40);
        exp_rd(cmp(3), 32'h40, "R3 load while disabled");
        step(31'h50);
        exp_pin(4'b0100, "R10 disabled channel no pulse");
        wr(ctl(2), 32'h0);
        tick();
        exp_pin(4'b0000, "R10 pin low in mode zero");

        @(negedge clk_i);
        #2;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule